// File: doc/BRIEF.md
# Integer and Float Conversion Unit

This unit converts between 32-bit two's-complement integers and IEEE-754 single-precision values. It is meant to sit beside a processor's floating-point datapath. A request is a valid strobe, an 8-bit minor opcode, one 32-bit operand word and a 2-bit rounding mode. The rounding mode comes from the floating-point control register. A recognised opcode is taken on the clock edge, and the result appears on the registered outputs one clock later.

Both directions round by the selected mode. Integer-to-float rounds the low bits it discards when the magnitude needs more than 24 significant bits. Float-to-integer rounds the fraction instead of cutting it off. Each result carries an inexact flag and an invalid flag. The surrounding control register can OR these flags into its sticky status bits.

Top module: `cvt_unit`

## Requirements
- R1: Minor opcode 0x04 selects integer-to-float and 0x05 selects float-to-integer. A valid input with any other opcode is ignored: `res_valid` stays low and `res_word` and both flags keep their previous values.
- R2: For each accepted request, `res_valid` is high for exactly the one cycle after the edge that took the request. Back-to-back requests give back-to-back results.
- R3: `rst_n` low clears `res_valid`, `res_word`, `res_inexact` and `res_invalid` to zero.
- R4: Rounding-mode encoding: 0 = nearest with ties to even, 1 = toward zero, 2 = toward +infinity, 3 = toward −infinity. Integer-to-float applies it to the bits discarded when |x| > 2^24.
- R5: Integer-to-float treats the operand as signed. It sets inexact exactly when a discarded bit was nonzero, and it never sets invalid.
- R6: Integer-to-float is exact for |x| ≤ 2^24. Integer 0 gives +0.0 (0x00000000), and 0x80000000 gives 0xCF000000.
- R7: Float-to-integer rounds a value with a fractional part by the selected mode. The 32-bit signed result fills the whole word.
- R8: Float-to-integer of NaN, ±infinity, or a value outside [−2^31, 2^31−1] gives 0x7FFFFFFF for positive non-NaN inputs. It gives 0x80000000 for negative inputs and for any NaN. In these cases invalid is set and inexact is clear. An input of exactly −2^31 (0xCF000000) converts to 0x80000000 with no flag.
- R9: Float-to-integer of +0.0 or −0.0 gives 0 with no flags. A denormal input gives 0, +1 or −1 according to its sign and the mode, with inexact set.
- R10: Float-to-integer sets inexact exactly when the input had a nonzero fractional part and was not invalid.
- R11: Inexact and invalid are never both set on a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| req_valid | input | 1 | Request strobe |
| req_op | input | 8 | Minor opcode |
| req_word | input | 32 | Operand word (integer or single-precision bits) |
| req_rmode | input | 2 | Rounding mode |
| res_valid | output | 1 | Result strobe, one cycle after acceptance |
| res_word | output | 32 | Converted result |
| res_inexact | output | 1 | Result was rounded |
| res_invalid | output | 1 | Float-to-integer input had no representable result |

## Verification
A new request can be accepted in the same cycle that the previous result is presented. An ignored opcode can also arrive in that cycle and must leave the presented result untouched. The bench drives a continuous stream with no idle cycles that mixes both conversion directions and unrecognised opcodes. Each result is judged in the cycle after its request, against reference functions. Those functions compute the rounding by integer comparison of the remainder against half an ulp. Directed ties, saturation bounds, denormals and signed zeros are placed inside this stream so that they meet the same overlap.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  localparam int INT_W  = 32;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int BIAS   = 127;
  localparam int SIG_W  = MAN_W + 1;
  localparam int LZC_W  = $clog2(INT_W) + 1;

  localparam logic [7:0] OP_I2F = 8'h04;
  localparam logic [7:0] OP_F2I = 8'h05;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_ZERO    = 2'd1,
    RM_UP      = 2'd2,
    RM_DOWN    = 2'd3
  } rmode_e;

  typedef struct packed {
    logic [INT_W-1:0] word;
    logic             inexact;
    logic             invalid;
  } cvt_res_t;

  // Decide whether the kept magnitude is bumped by one unit in the last place.
  function automatic logic round_bump(input logic sgn, input logic lsb,
                                      input logic grd, input logic stk,
                                      input logic [1:0] rm);
    logic b;
    case (rmode_e'(rm))
      RM_NEAREST: b = grd & (stk | lsb);
      RM_ZERO:    b = 1'b0;
      RM_UP:      b = ~sgn & (grd | stk);
      default:    b = sgn & (grd | stk);
    endcase
    return b;
  endfunction
endpackage

// File: rtl/cvt_lzc.sv
module cvt_lzc
  import cvt_pkg::*;
#(
  parameter int W  = INT_W,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] zeros
);
  // Highest set bit wins; an all-zero vector reports W.
  always_comb begin
    zeros = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) zeros = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/cvt_i2f.sv
module cvt_i2f
  import cvt_pkg::*;
(
  input  logic [INT_W-1:0] ival,
  input  logic [1:0]       rm,
  output cvt_res_t         res
);
  localparam int GRD_IX = INT_W - 2 - MAN_W;
  localparam logic [EXP_W-1:0] TOP_EXP = EXP_W'(BIAS + INT_W - 1);

  logic                  sgn;
  logic [INT_W-1:0]      mag;
  logic [LZC_W-1:0]      lz;
  logic [INT_W-1:0]      norm;
  logic [MAN_W-1:0]      mant;
  logic                  grd, stk, bump;
  logic [EXP_W-1:0]      expo;
  logic [EXP_W+MAN_W-1:0] body;

  assign sgn = ival[INT_W-1];
  assign mag = sgn ? (~ival + 1'b1) : ival;

  cvt_lzc #(.W(INT_W), .CW(LZC_W)) u_lzc (
    .vec   (mag),
    .zeros (lz)
  );

  always_comb begin
    norm = mag << lz;
    mant = norm[INT_W-2 -: MAN_W];
    grd  = norm[GRD_IX];
    stk  = |norm[GRD_IX-1:0];
    bump = round_bump(sgn, norm[GRD_IX+1], grd, stk, rm);
    expo = TOP_EXP - EXP_W'(lz);
    // A carry out of the mantissa moves into the exponent field by itself.
    body = {expo, mant} + {{(EXP_W+MAN_W-1){1'b0}}, bump};
    if (!norm[INT_W-1]) begin
      res.word    = '0;
      res.inexact = 1'b0;
    end else begin
      res.word    = {sgn, body};
      res.inexact = grd | stk;
    end
    res.invalid = 1'b0;
  end
endmodule

// File: rtl/cvt_f2i.sv
module cvt_f2i
  import cvt_pkg::*;
(
  input  logic [INT_W-1:0] fval,
  input  logic [1:0]       rm,
  output cvt_res_t         res
);
  localparam logic [EXP_W-1:0] INT_EXP = EXP_W'(BIAS + MAN_W);       // weight of the lsb is 1
  localparam logic [EXP_W-1:0] OVF_EXP = EXP_W'(BIAS + INT_W - 1);   // magnitude reaches 2^(INT_W-1)
  localparam logic [EXP_W-1:0] MAX_RSH = EXP_W'(SIG_W + 2);          // further shifts change nothing
  localparam int               XW      = SIG_W + INT_W;

  logic                  sgn, special, nan_in, big, min_exact, bump;
  logic [EXP_W-1:0]      e, ee, lsh, rsh;
  logic [MAN_W-1:0]      fr;
  logic [SIG_W-1:0]      sig;
  logic [XW-1:0]         x;
  logic [INT_W-1:0]      m, mr;
  logic                  grd, stk;

  assign sgn = fval[INT_W-1];
  assign e   = fval[INT_W-2 -: EXP_W];
  assign fr  = fval[MAN_W-1:0];

  always_comb begin
    sig       = {|e, fr};
    ee        = (e == '0) ? EXP_W'(1) : e;
    special   = &e;
    nan_in    = special & (|fr);
    big       = ee >= OVF_EXP;
    min_exact = sgn & (e == OVF_EXP) & (fr == '0);
    lsh       = ee - INT_EXP;
    rsh       = INT_EXP - ee;
    if (rsh > MAX_RSH) rsh = MAX_RSH;
    x         = {sig, {INT_W{1'b0}}} >> rsh;
    if (ee >= INT_EXP) begin
      m   = {{(INT_W-SIG_W){1'b0}}, sig} << lsh;
      grd = 1'b0;
      stk = 1'b0;
    end else begin
      m   = {{(INT_W-SIG_W){1'b0}}, x[XW-1 -: SIG_W]};
      grd = x[INT_W-1];
      stk = |x[INT_W-2:0];
    end
    bump = round_bump(sgn, m[0], grd, stk, rm);
    mr   = m + {{(INT_W-1){1'b0}}, bump};

    if (special || (big && !min_exact)) begin
      res.word    = (sgn || nan_in) ? {1'b1, {(INT_W-1){1'b0}}}
                                    : {1'b0, {(INT_W-1){1'b1}}};
      res.inexact = 1'b0;
      res.invalid = 1'b1;
    end else if (min_exact) begin
      res.word    = {1'b1, {(INT_W-1){1'b0}}};
      res.inexact = 1'b0;
      res.invalid = 1'b0;
    end else begin
      res.word    = sgn ? (~mr + 1'b1) : mr;
      res.inexact = grd | stk;
      res.invalid = 1'b0;
    end
  end
endmodule

// File: rtl/cvt_unit.sv
module cvt_unit
  import cvt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [7:0]        req_op,
  input  logic [INT_W-1:0]  req_word,
  input  logic [1:0]        req_rmode,
  output logic              res_valid,
  output logic [INT_W-1:0]  res_word,
  output logic              res_inexact,
  output logic              res_invalid
);
  cvt_res_t i2f_res, f2i_res;
  cvt_res_t sel_res, res_q, res_d;
  logic     take, pick_f2i, vld_d, vld_q;

  cvt_i2f u_i2f (.ival(req_word), .rm(req_rmode), .res(i2f_res));
  cvt_f2i u_f2i (.fval(req_word), .rm(req_rmode), .res(f2i_res));

  // Next-state logic
  always_comb begin
    pick_f2i = (req_op == OP_F2I);
    take     = req_valid & ((req_op == OP_I2F) | pick_f2i);
    sel_res  = pick_f2i ? f2i_res : i2f_res;
    res_d    = take ? sel_res : res_q;
    vld_d    = take;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (take) res_q <= res_d;
    end
  end

  assign res_valid   = vld_q;
  assign res_word    = res_q.word;
  assign res_inexact = res_q.inexact;
  assign res_invalid = res_q.invalid;

  p_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op == OP_I2F || req_op == OP_F2I)) |=> res_valid);
  p_ignore_op_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && (req_op == OP_I2F || req_op == OP_F2I)) |=> (!res_valid && $stable(res_word)));
  p_i2f_no_invalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_I2F) |=> !res_invalid);
  p_i2f_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_I2F && req_word == '0) |=> (res_word == '0 && !res_inexact));
  p_special_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_F2I && (&req_word[INT_W-2 -: EXP_W])) |=> (res_invalid && !res_inexact));
  p_flags_apart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_inexact && res_invalid));
endmodule

// File: tb/cvt_unit_tb.sv
module cvt_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [7:0]  req_op;
  logic [31:0] req_word;
  logic [1:0]  req_rmode;
  logic        res_valid;
  logic [31:0] res_word;
  logic        res_inexact, res_invalid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic        exp_v;
  logic [31:0] exp_w;
  logic        exp_x, exp_i;
  string       exp_tag;

  cvt_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_word(req_word), .req_rmode(req_rmode), .res_valid(res_valid),
    .res_word(res_word), .res_inexact(res_inexact), .res_invalid(res_invalid)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, expv);
    end
  endtask

  // Reference: remainder compared against half an ulp
  function automatic logic bump_ref(input bit s, input bit odd, input bit gt, input bit eq, input bit nz, input logic [1:0] rm);
    case (rm)
      2'd0: return gt || (eq && odd);
      2'd1: return 1'b0;
      2'd2: return !s && nz;
      default: return s && nz;
    endcase
  endfunction

  function automatic logic [33:0] ref_i2f(input logic [31:0] a, input logic [1:0] rm);
    longint v, mag, q, rem, half;
    int p, k;
    bit s, inx;
    v = longint'($signed(a));
    s = v < 0;
    mag = s ? -v : v;
    if (mag == 0) return 34'd0;
    p = 0;
    for (int i = 0; i < 40; i++) if (mag[i]) p = i;
    inx = 0;
    if (p <= 23) q = mag << (23 - p);
    else begin
      k = p - 23;
      q = mag >> k;
      rem = mag - (q << k);
      half = longint'(1) << (k - 1);
      inx = rem != 0;
      if (bump_ref(s, q[0], rem > half, rem == half, rem != 0, rm)) q = q + 1;
      if (q == (longint'(1) << 24)) begin q = q >> 1; p = p + 1; end
    end
    return {1'b0, inx, s, 8'(p + 127), q[22:0]};
  endfunction

  function automatic logic [33:0] ref_f2i(input logic [31:0] f, input logic [1:0] rm);
    bit s;
    int e, ee, sh;
    longint sig, q, rem, half, r;
    bit gt, eq, nz;
    s = f[31];
    e = int'(f[30:23]);
    if (e == 255) return {1'b1, 1'b0, ((s || f[22:0] != 0) ? 32'h80000000 : 32'h7FFFFFFF)};
    if (e >= 158) begin
      if (s && e == 158 && f[22:0] == 0) return {2'b00, 32'h80000000};
      return {1'b1, 1'b0, (s ? 32'h80000000 : 32'h7FFFFFFF)};
    end
    sig = longint'(f[22:0]) + ((e != 0) ? (longint'(1) << 23) : 0);
    ee = (e == 0) ? 1 : e;
    gt = 0; eq = 0; nz = 0;
    if (ee >= 150) q = sig << (ee - 150);
    else begin
      sh = 150 - ee;
      if (sh > 40) begin q = 0; nz = sig != 0; end
      else begin
        q = sig >> sh;
        rem = sig - (q << sh);
        half = longint'(1) << (sh - 1);
        gt = rem > half; eq = rem == half; nz = rem != 0;
      end
    end
    if (bump_ref(s, q[0], gt, eq, nz, rm)) q = q + 1;
    r = s ? -q : q;
    return {1'b0, nz, r[31:0]};
  endfunction

  task automatic verify();
    chk(exp_tag, "valid", {31'b0, res_valid}, {31'b0, exp_v});
    chk(exp_tag, "word", res_word, exp_w);
    if (exp_v) begin
      chk(exp_tag, "inexact", {31'b0, res_inexact}, {31'b0, exp_x});
      chk(exp_tag, "invalid", {31'b0, res_invalid}, {31'b0, exp_i});
    end
  endtask

  task automatic step(input logic [7:0] op, input logic [31:0] w, input logic [1:0] rm, input string tag);
    logic [33:0] r;
    @(negedge clk);
    verify();
    req_valid = 1'b1; req_op = op; req_word = w; req_rmode = rm;
    exp_tag = tag;
    if (op == 8'h04 || op == 8'h05) begin
      r = (op == 8'h04) ? ref_i2f(w, rm) : ref_f2i(w, rm);
      exp_v = 1'b1; exp_w = r[31:0]; exp_x = r[32]; exp_i = r[33];
    end else exp_v = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_word = '0; req_rmode = '0;
    exp_v = 0; exp_w = '0; exp_x = 0; exp_i = 0; exp_tag = "R3";
    repeat (3) @(negedge clk);
    verify(); // R3 reset state
    chk("R3", "inexact", {31'b0, res_inexact}, 32'd0);
    chk("R3", "invalid", {31'b0, res_invalid}, 32'd0);
    rst_n = 1'b1;

    // R6 exact integer to float
    step(8'h04, 32'd0, 2'd2, "R6");
    step(8'h04, 32'd1, 2'd0, "R6");
    step(8'h04, 32'hFFFFFFFF, 2'd0, "R6");
    step(8'h04, 32'd16777216, 2'd3, "R6");
    step(8'h04, 32'h80000000, 2'd0, "R6");
    // R4 R5 rounding of discarded bits
    for (int m = 0; m < 4; m++) begin
      step(8'h04, 32'd16777217, 2'(m), "R4");
      step(8'h04, 32'd16777219, 2'(m), "R4");
      step(8'h04, -32'sd16777217, 2'(m), "R5");
      step(8'h04, 32'h7FFFFFFF, 2'(m), "R5");
    end
    // R1 ignored opcodes between live requests
    step(8'h00, 32'h12345678, 2'd0, "R1");
    step(8'h06, 32'h40200000, 2'd1, "R1");
    step(8'h05, 32'h40200000, 2'd0, "R7");
    step(8'h14, 32'h00000001, 2'd0, "R1");
    // R7 R10 ties and fractions
    for (int m = 0; m < 4; m++) begin
      step(8'h05, 32'h40200000, 2'(m), "R7");
      step(8'h05, 32'h40600000, 2'(m), "R7");
      step(8'h05, 32'hC0200000, 2'(m), "R10");
      step(8'h05, 32'h3F000000, 2'(m), "R10");
      step(8'h05, 32'h00000001, 2'(m), "R9");
      step(8'h05, 32'h80000001, 2'(m), "R9");
    end
    // R8 R9 specials and bounds
    step(8'h05, 32'h7FC00000, 2'd0, "R8");
    step(8'h05, 32'hFFC00000, 2'd0, "R8");
    step(8'h05, 32'h7F800000, 2'd1, "R8");
    step(8'h05, 32'hFF800000, 2'd2, "R8");
    step(8'h05, 32'h4F000000, 2'd0, "R8");
    step(8'h05, 32'hCF000000, 2'd0, "R8");
    step(8'h05, 32'hCF000001, 2'd0, "R8");
    step(8'h05, 32'h4EFFFFFF, 2'd2, "R8");
    step(8'h05, 32'h00000000, 2'd2, "R9");
    step(8'h05, 32'h80000000, 2'd3, "R9");
    // R2 R11 unbroken random stream
    for (int n = 0; n < 3000; n++) begin
      int sel;
      logic [31:0] w;
      logic [7:0] op;
      sel = int'($urandom % 8);
      w = $urandom;
      if (sel < 3) op = 8'h04;
      else if (sel < 7) op = 8'h05;
      else op = 8'($urandom);
      if (op == 8'h05 && ($urandom % 4) != 0) w[30:23] = 8'(110 + $urandom % 52);
      if (op == 8'h04 && ($urandom % 3) == 0) w = w >>> ($urandom % 32);
      step(op, w, 2'($urandom), (op == 8'h04) ? "R2" : "R11");
    end
    @(negedge clk);
    verify();
    req_valid = 1'b0;
    exp_v = 1'b0; exp_tag = "R2";
    @(negedge clk);
    verify();
    // R3 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    exp_w = '0; exp_tag = "R3";
    verify();
    chk("R3", "inexact", {31'b0, res_inexact}, 32'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule